// File: doc/BRIEF.md
# Smart Card Clock Generator

This block derives the clock that drives a smart card contact from a fast reference clock. Software, or a control block beside it, chooses one of four division ratios, can park the card clock at a chosen high or low level, and decides whether the data line coming back from the card reaches the host side. The card clock is a register output, so it carries no combinational glitches. A ratio change, a stop request and a restart all take effect only on half-period boundaries. Because of this, no high or low phase is ever shorter than the half period of the rate that produced it.

The reference clock `ref_clk` runs at twice the nominal input clock. One `ref_clk` cycle is therefore half an input-clock period. The ratios are given relative to the input clock: /8, /4, /2 and /1 give card-clock half periods of 8, 4, 2 and 1 `ref_clk` cycles. Every other control pin is a plain level, sampled on the rising edge of `ref_clk`. There is no data stream, so there is no handshake. The returned card data is gated combinationally, and its output enable is registered.

Top module: `card_clk_gen`

## Requirements
- R1: The rate select sets the card-clock half period in `ref_clk` cycles: code 00 gives 8 (input/8), 01 gives 4 (input/4), 10 gives 2 (input/2) and 11 gives 1 (input/1). While running, every high and low phase lasts exactly that many cycles.
- R2: A new rate select value does not shorten or stretch the phase in progress. It is sampled on the edge where the card clock toggles (or restarts), and it sets the length of the phase that begins there.
- R3: If `clk_stop` is 1 at a half-period boundary and the card clock already equals `stop_level`, the card clock stays at that level. It holds for as long as `clk_stop` stays 1 and `stop_level` is unchanged.
- R4: If `clk_stop` is 1 at a boundary while the card clock is at the other level, the card clock toggles normally. It then completes a full half period at the requested level before it parks.
- R5: After `clk_stop` returns to 0 while parked, the first card-clock edge comes exactly one half period after the first `ref_clk` edge that samples the release. The half period uses the rate select sampled on that same edge.
- R6: While parked, a change of `stop_level` away from the parked level acts like a release. The clock restarts after a full half period, reaches the new level, and parks there at the next boundary.
- R7: `host_io_oe` equals `io_en` delayed by one `ref_clk` edge. While `host_io_oe` is 1, `host_io_o` follows `card_io_in`. While it is 0, `host_io_o` is 0 and the host side is high impedance.
- R8: While `rst_n` is 0, `card_clk` is 0 and `host_io_oe` is 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock, twice the nominal input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | SEL_W (2) | Division ratio code |
| clk_stop | input | 1 | Request to park the card clock |
| stop_level | input | 1 | Level at which the card clock parks (1 high, 0 low) |
| io_en | input | 1 | Enables passing card data to the host side |
| card_io_in | input | 1 | Data received from the card contact |
| card_clk | output | 1 | Clock to the card |
| host_io_o | output | 1 | Card data towards the host, 0 when disabled |
| host_io_oe | output | 1 | Output enable for the host-side data line |

## Verification
A change of the rate select and a restart from the parked state can land on the same reference edge. The reload at the restart must take the new ratio and not the one in force before the stop. The bench changes the rate select in the same cycle that it drops `clk_stop`. It then expects the first post-release phase, and the phase after it, to have the new length. The scoreboard receives every high and low phase as a level and length pair and compares it with a precomputed list. A stale ratio would therefore show up as a length mismatch at that exact phase.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  // Divider control state: running or parked at a level.
  typedef enum logic {
    CCG_RUN  = 1'b0,
    CCG_PARK = 1'b1
  } ccg_state_e;

  // Counter width able to hold the largest half-period minus one.
  function automatic int unsigned ccg_cnt_w(input int unsigned max_shift);
    return (max_shift < 1) ? 1 : max_shift;
  endfunction

endpackage

// File: rtl/ccg_rate_ctrl.sv
module ccg_rate_ctrl #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic [SEL_W-1:0] rate_sel,
  output logic [CNT_W-1:0] reload_val
);
  localparam int unsigned NCODE     = 2 ** SEL_W;
  localparam int unsigned MAX_SHIFT = NCODE - 1;

  // Half period per code: the highest code has length 1, and each step down doubles it.
  logic [CNT_W-1:0] half_m1 [NCODE];

  for (genvar gi = 0; gi < NCODE; gi++) begin : g_code
    assign half_m1[gi] = CNT_W'((1 << (MAX_SHIFT - gi)) - 1);
  end

  assign reload_val = half_m1[rate_sel];

endmodule

// File: rtl/ccg_divider.sv
module ccg_divider
  import ccg_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             clk_stop,
  input  logic             stop_level,
  output logic             card_clk
);
  ccg_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clk_q;

  logic hold_req, at_bnd, wake, do_toggle, load;

  // The stop request is met when the output already sits at the requested level.
  assign hold_req  = clk_stop && (clk_q == stop_level);
  assign at_bnd    = (state_q == CCG_RUN) && (cnt_q == '0);
  assign wake      = (state_q == CCG_PARK) && !hold_req;
  assign do_toggle = at_bnd && !hold_req;
  assign load      = do_toggle || wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CCG_PARK;
      cnt_q   <= '0;
      clk_q   <= 1'b0;
    end else if (wake) begin
      // Restart: a full half period passes before the first edge.
      state_q <= CCG_RUN;
      cnt_q   <= reload_val;
    end else if (do_toggle) begin
      clk_q <= ~clk_q;
      cnt_q <= reload_val;
    end else if (at_bnd) begin
      state_q <= CCG_PARK;
    end else if (state_q == CCG_RUN) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign card_clk = clk_q;

  // ---------------- checks ----------------
  // Phase-length monitor: the cycles since the last reload, and the reload length itself.
  logic [CNT_W:0]   run_q;
  logic [CNT_W-1:0] span_q;
  logic             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      span_q <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= clk_q;
      if (load) begin
        run_q  <= '0;
        span_q <= reload_val;
      end else if (run_q != '1) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R1, R2, R5: each edge ends a phase exactly as long as the length loaded when the phase began.
  a_r1_half_len: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_q != prev_q) |-> ($past(run_q) == {1'b0, $past(span_q)}));

  // R3: while parked at the requested level with the stop request held, the output does not move.
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == CCG_PARK) && clk_stop && (stop_level == clk_q)) |=> $stable(clk_q));

  // R4: parking happens only at the level that was requested.
  a_r4_park_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == CCG_PARK) |-> (clk_q == $past(stop_level)));

endmodule

// File: rtl/ccg_io_gate.sv
module ccg_io_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic io_en,
  input  logic card_io_in,
  output logic host_io_o,
  output logic host_io_oe
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= io_en;
  end

  assign host_io_oe = en_q;
  assign host_io_o  = en_q & card_io_in;

  // R7: the enable follows the control bit by one edge.
  a_r7_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (host_io_oe == $past(io_en)));

  // R7: the data line is quiet while the host side is released.
  a_r7_hiz_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !host_io_oe |-> (host_io_o == 1'b0));

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import ccg_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             clk_stop,
  input  logic             stop_level,
  input  logic             io_en,
  input  logic             card_io_in,
  output logic             card_clk,
  output logic             host_io_o,
  output logic             host_io_oe
);
  localparam int unsigned MAX_SHIFT = (2 ** SEL_W) - 1;
  localparam int unsigned CNT_W     = ccg_cnt_w(MAX_SHIFT);

  logic [CNT_W-1:0] reload_val;

  ccg_rate_ctrl #(
    .SEL_W (SEL_W),
    .CNT_W (CNT_W)
  ) u_rate (
    .rate_sel   (rate_sel),
    .reload_val (reload_val)
  );

  ccg_divider #(
    .CNT_W (CNT_W)
  ) u_div (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .reload_val (reload_val),
    .clk_stop   (clk_stop),
    .stop_level (stop_level),
    .card_clk   (card_clk)
  );

  ccg_io_gate u_io (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .io_en      (io_en),
    .card_io_in (card_io_in),
    .host_io_o  (host_io_o),
    .host_io_oe (host_io_oe)
  );

endmodule

// File: tb/card_clk_gen_bench.sv
module card_clk_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    bit    lvl;
    int    len;
    string req;
  } phase_t;

  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic [1:0] rate_sel;
  logic       clk_stop, stop_level, io_en, card_io_in;
  logic       card_clk, host_io_o, host_io_oe;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  phase_t exp_q[$];
  bit     mon_on     = 1'b1;
  bit     have_start = 1'b0;
  bit     last_lvl   = 1'b0;
  int     run        = 0;
  int     n_chg      = 0;

  card_clk_gen u_card_clk_gen (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .clk_stop   (clk_stop),
    .stop_level (stop_level),
    .io_en      (io_en),
    .card_io_in (card_io_in),
    .card_clk   (card_clk),
    .host_io_o  (host_io_o),
    .host_io_oe (host_io_oe)
  );

  always #(CLK_PERIOD / 2) ref_clk = ~ref_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input bit lvl, input int len, input string req);
    phase_t p;
    p.lvl = lvl;
    p.len = len;
    p.req = req;
    exp_q.push_back(p);
  endtask

  // Monitor: measure each completed high/low phase and compare it with the scoreboard.
  // A phase value is shown as level*1000 + length.
  always @(negedge ref_clk) begin
    if (mon_on) begin
      if (card_clk !== last_lvl) begin
        n_chg++;
        if (have_start && exp_q.size() > 0) begin
          phase_t p;
          p = exp_q.pop_front();
          chk((p.lvl == last_lvl) && (p.len == run), p.req,
              int'(last_lvl) * 1000 + run, int'(p.lvl) * 1000 + p.len);
        end
        have_start = 1'b1;
        run        = 1;
        last_lvl   = card_clk;
      end else begin
        run++;
      end
    end
  end

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b1;
    rate_sel   = 2'b00;
    clk_stop   = 1'b0;
    stop_level = 1'b0;
    io_en      = 1'b1;
    card_io_in = 1'b1;
    #1 rst_n   = 1'b0;

    // Expected phases, from the first card-clock edge onwards.
    push(1, 8, "R1"); push(0, 8, "R1"); push(1, 8, "R1"); push(0, 8, "R1");
    push(1, 8, "R2"); push(0, 4, "R2"); push(1, 4, "R1"); push(0, 4, "R1");
    push(1, 4, "R2"); push(0, 1, "R2"); push(1, 1, "R1"); push(0, 2, "R2");
    push(1, 2, "R1"); push(0, 2, "R1"); push(1, 2, "R1"); push(0, 2, "R4");
    push(1, 24, "R4");  // toggled up, parked high, released with the new rate
    push(0, 16, "R3");  // parked low at once, then woken by the level change
    push(1, 10, "R6");  // restart after the level change, park high, release
    push(0, 4, "R5");
    push(1, 4, "R1");

    repeat (3) @(negedge ref_clk);
    chk(card_clk == 1'b0, "R8", int'(card_clk), 0);
    chk(host_io_oe == 1'b0, "R8", int'(host_io_oe), 0);
    io_en = 1'b0;
    card_io_in = 1'b0;
    rst_n = 1'b1;

    // Rate 00 -> 01 in the middle of a high phase.
    wait (n_chg >= 5);
    @(negedge ref_clk) rate_sel = 2'b01;
    // Rate 01 -> 11 in the middle of a high phase.
    wait (n_chg >= 9);
    @(negedge ref_clk) rate_sel = 2'b11;
    // Rate 11 -> 10 while toggling every cycle.
    wait (n_chg >= 10);
    @(negedge ref_clk) rate_sel = 2'b10;
    // Stop high while the clock is low.
    wait (n_chg >= 16);
    @(negedge ref_clk) begin clk_stop = 1'b1; stop_level = 1'b1; end
    repeat (10) @(negedge ref_clk);
    chk(card_clk == 1'b1, "R4", int'(card_clk), 1);
    repeat (10) @(negedge ref_clk);
    // Release and a new rate in the same cycle.
    clk_stop = 1'b0;
    rate_sel = 2'b01;
    // Stop low while the clock is already low.
    wait (n_chg >= 18);
    @(negedge ref_clk) begin clk_stop = 1'b1; stop_level = 1'b0; end
    repeat (5) @(negedge ref_clk);
    chk(card_clk == 1'b0, "R3", int'(card_clk), 0);
    repeat (5) @(negedge ref_clk);
    stop_level = 1'b1;
    repeat (10) @(negedge ref_clk);
    chk(card_clk == 1'b1, "R6", int'(card_clk), 1);
    clk_stop = 1'b0;

    wait (exp_q.size() == 0);
    chk(exp_q.size() == 0, "R1", exp_q.size(), 0);

    // Data gating towards the host side.
    @(negedge ref_clk);
    chk(host_io_oe == 1'b0, "R7", int'(host_io_oe), 0);
    io_en = 1'b1;
    card_io_in = 1'b1;
    chk(host_io_o == 1'b0, "R7", int'(host_io_o), 0);
    @(negedge ref_clk);
    chk(host_io_oe == 1'b1, "R7", int'(host_io_oe), 1);
    chk(host_io_o == 1'b1, "R7", int'(host_io_o), 1);
    card_io_in = 1'b0;
    #1 chk(host_io_o == 1'b0, "R7", int'(host_io_o), 0);
    @(negedge ref_clk);
    io_en = 1'b0;
    card_io_in = 1'b1;
    @(negedge ref_clk);
    chk(host_io_oe == 1'b0, "R7", int'(host_io_oe), 0);
    chk(host_io_o == 1'b0, "R7", int'(host_io_o), 0);

    // Reset in the middle of operation, with the enable requested.
    io_en = 1'b1;
    @(negedge ref_clk);
    mon_on = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(card_clk == 1'b0, "R8", int'(card_clk), 0);
    chk(host_io_oe == 1'b0, "R8", int'(host_io_oe), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule